// File: doc/BRIEF.md
# Power Mode Sequencer

This block tracks the operating mode of a small embedded controller across six modes. Ordered from most to least active, they are high-speed PLL, low-speed PLL, doze, sleep, suspend and off. An asynchronous suspend/resume input is synchronised and edge-detected. In one of the three upper modes, a rising edge arms a stepped descent that moves down one mode per refresh tick and stops at sleep. In sleep, suspend or off, the same edge returns the block to high-speed PLL at once. From sleep, a one-cycle software request can move the block on to suspend or off.

A small table holds the level of each power-control pin for every mode, and the pins follow the row of the current mode. Out of reset the pins show a fixed safe pattern: pins 0 to 2 are low and pin 3 is high. This pattern holds until the table is first written or the mode first changes. The current mode is reported on a 3-bit output, and a one-cycle pulse marks every mode change. All pins are plain control and status signals, and no back-pressure exists anywhere.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the mode is high-speed PLL (code 0), no descent is armed, `mode_chg_o` is low and `pwr_pins_o` is 4'b1000.
- R2: `sus_res_i` passes through two synchroniser flops before a rising-edge detector. A rise driven just before clock edge k takes effect at edge k+2. Holding the input high causes no further action.
- R3: A suspend/resume edge in high-speed PLL, low-speed PLL or doze arms a descent and leaves the mode unchanged. While armed, each `refresh_tick_i` lowers the mode by exactly one. The descent stops on reaching sleep. Refresh ticks have no effect when no descent is armed.
- R4: A suspend/resume edge that arrives while a descent is armed is ignored.
- R5: A suspend/resume edge in sleep, suspend or off moves the mode directly to high-speed PLL.
- R6: `pwr_pins_o` equals the table row selected by the current mode. A write with `cfg_we_i` high stores `cfg_wdata_i` in row `cfg_addr_i`, where the row index equals the mode code. Addresses 6 and 7 are ignored.
- R7: The reset pin pattern is released on the first table write or on the first mode change. After that the pins always follow the table.
- R8: `req_valid_i` with `req_mode_i` = 2'b00 requests suspend, and 2'b01 requests off. A request is accepted only in sleep. All other codes, and requests in any other mode, have no effect. A suspend/resume edge in the same cycle takes precedence.
- R9: `mode_o` uses the codes high-speed PLL=0, low-speed PLL=1, doze=2, sleep=3, suspend=4 and off=5. `mode_chg_o` is high for exactly the first cycle of each new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sus_res_i | input | 1 | Asynchronous suspend/resume request, rising-edge active |
| refresh_tick_i | input | 1 | One-cycle refresh tick that paces the descent |
| cfg_we_i | input | 1 | Pin table write enable |
| cfg_addr_i | input | 3 | Pin table row (mode code) |
| cfg_wdata_i | input | 4 | Pin levels for that row |
| req_valid_i | input | 1 | One-cycle software mode request |
| req_mode_i | input | 2 | Requested mode: 00 suspend, 01 off |
| pwr_pins_o | output | 4 | Power-control pin levels |
| mode_o | output | 3 | Current mode code |
| mode_chg_o | output | 1 | One-cycle pulse on each mode change |

## Verification
An armed-descent flag that is wrongly set or cleared is invisible until the next refresh tick. The fault then shows at the ports as a missing or extra mode step and `mode_chg_o` pulse on the cycle after that tick. For this reason the bench applies ticks both with and without an armed descent. A corrupted mode register shows immediately on `mode_o` and selects the wrong table row on `pwr_pins_o` in the same cycle. A stuck override bit shows as the pins holding 4'b1000 after the first table write.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int NUM_MODES = 6;
  localparam int MODE_W    = 3;
  localparam int REQ_W     = 2;

  typedef enum logic [MODE_W-1:0] {
    M_HSPLL = 3'd0,
    M_LSPLL = 3'd1,
    M_DOZE  = 3'd2,
    M_SLEEP = 3'd3,
    M_SUSP  = 3'd4,
    M_OFF   = 3'd5
  } pmode_e;

  localparam logic [REQ_W-1:0] REQ_SUSP = 2'b00;
  localparam logic [REQ_W-1:0] REQ_OFF  = 2'b01;
endpackage

// File: rtl/sr_edge_sync.sv
module sr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= async_i;
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pmode_fsm.sv
module pmode_fsm
  import pwr_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             tick_i,
  input  logic             req_valid_i,
  input  logic [REQ_W-1:0] req_mode_i,
  output pmode_e           mode_o,
  output logic             chg_o
);
  pmode_e mode_q, mode_d;
  logic   desc_q, desc_d;
  logic   chg_q;

  always_comb begin
    mode_d = mode_q;
    desc_d = desc_q;
    if (rise_i && mode_q >= M_SLEEP) begin
      mode_d = M_HSPLL;
      desc_d = 1'b0;
    end else if (rise_i && !desc_q) begin
      desc_d = 1'b1;
    end else if (desc_q && tick_i) begin
      mode_d = pmode_e'(mode_q + 3'd1);
      if (mode_d == M_SLEEP) desc_d = 1'b0;
    end else if (req_valid_i && mode_q == M_SLEEP) begin
      if (req_mode_i == REQ_SUSP)     mode_d = M_SUSP;
      else if (req_mode_i == REQ_OFF) mode_d = M_OFF;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_HSPLL;
      desc_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      desc_q <= desc_d;
      chg_q  <= (mode_d != mode_q);
    end
  end

  assign mode_o = mode_q;
  assign chg_o  = chg_q;
endmodule

// File: rtl/pin_table.sv
module pin_table
  import pwr_mode_pkg::*;
#(
  parameter int               PIN_W      = 4,
  parameter int               ADDR_W     = 3,
  parameter logic [PIN_W-1:0] RESET_PINS = 4'b1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PIN_W-1:0]  wdata_i,
  input  pmode_e            mode_i,
  input  logic              chg_i,
  output logic [PIN_W-1:0]  pins_o
);
  logic [PIN_W-1:0] row_q [NUM_MODES];
  logic [PIN_W-1:0] row_sel;
  logic             ovr_q;

  genvar g;
  generate
    for (g = 0; g < NUM_MODES; g++) begin : g_row
      always_ff @(posedge clk) begin
        if (!rst_n)                                     row_q[g] <= '0;
        else if (we_i && addr_i == ADDR_W'(g))          row_q[g] <= wdata_i;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)            ovr_q <= 1'b1;
    else if (we_i || chg_i) ovr_q <= 1'b0;
  end

  always_comb begin
    row_sel = '0;
    for (int i = 0; i < NUM_MODES; i++)
      if (mode_i == pmode_e'(i)) row_sel = row_q[i];
  end

  assign pins_o = (ovr_q && !chg_i) ? RESET_PINS : row_sel;
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int               PIN_W      = 4,
  parameter int               SYNC_STG   = 2,
  parameter logic [PIN_W-1:0] RESET_PINS = 4'b1000,
  localparam int              ADDR_W     = $clog2(NUM_MODES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sus_res_i,
  input  logic              refresh_tick_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [PIN_W-1:0]  cfg_wdata_i,
  input  logic              req_valid_i,
  input  logic [REQ_W-1:0]  req_mode_i,
  output logic [PIN_W-1:0]  pwr_pins_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              mode_chg_o
);
  logic   rise;
  pmode_e mode;
  logic   chg;

  sr_edge_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sus_res_i), .rise_o(rise)
  );

  pmode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .tick_i(refresh_tick_i),
    .req_valid_i(req_valid_i), .req_mode_i(req_mode_i),
    .mode_o(mode), .chg_o(chg)
  );

  pin_table #(.PIN_W(PIN_W), .ADDR_W(ADDR_W), .RESET_PINS(RESET_PINS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .mode_i(mode), .chg_i(chg), .pins_o(pwr_pins_o)
  );

  assign mode_o     = mode;
  assign mode_chg_o = chg;
endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_o,
  input logic       mode_chg_o
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_mode_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 3'd5);

  assert_chg_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (mode_chg_o == (mode_o != $past(mode_o))));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode_o != $past(mode_o) && $past(mode_o) < 3'd3)
      |-> (mode_o == $past(mode_o) + 3'd1));

  assert_low_from_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode_o > 3'd3 && mode_o != $past(mode_o))
      |-> ($past(mode_o) == 3'd3));

  assert_rise_to_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mode_o < $past(mode_o)) |-> (mode_o == 3'd0));
endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .mode_chg_o(mode_chg_o)
);

// File: tb/pwr_mode_seq_tb.sv
module pwr_mode_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sus_res = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [3:0] wdata = '0;
  logic       rq = 1'b0;
  logic [1:0] rq_mode = '0;
  logic [3:0] pins;
  logic [2:0] mode;
  logic       chg;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [2:0] exp_q[$];

  always #10 clk = ~clk;

  pwr_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sus_res_i(sus_res), .refresh_tick_i(tick),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .req_valid_i(rq), .req_mode_i(rq_mode),
    .pwr_pins_o(pins), .mode_o(mode), .mode_chg_o(chg)
  );

  function automatic logic [3:0] pat(int m);
    return 4'((m * 5 + 3) & 15);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every mode-change pulse must match the next expected mode (R9)
  always @(negedge clk) begin
    if (rst_n && chg) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected change", mode, -1);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        check(mode == e, "R9 mode after change", mode, e);
      end
    end
  end

  task automatic expect_mode(input logic [2:0] m);
    exp_q.push_back(m);
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic pulse_sr();
    @(negedge clk) sus_res = 1'b1;
    repeat (3) @(negedge clk);
    sus_res = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg_wr(input logic [2:0] a, input logic [3:0] d);
    @(negedge clk) begin we = 1'b1; addr = a; wdata = d; end
    @(negedge clk) we = 1'b0;
  endtask

  task automatic req(input logic [1:0] c);
    @(negedge clk) begin rq = 1'b1; rq_mode = c; end
    @(negedge clk) rq = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mode == 3'd0, "R1 reset mode", mode, 0);
    check(pins == 4'b1000, "R1 reset pins", pins, 8);
    check(chg == 1'b0, "R1 reset chg", chg, 0);

    // R7: first write releases override; mode 0 row still zero
    cfg_wr(3'd1, pat(1));
    check(pins == 4'd0, "R7 release on write", pins, 0);
    for (int m = 0; m < 6; m++) cfg_wr(3'(m), pat(m));
    cfg_wr(3'd6, 4'hF);  // ignored address
    check(pins == pat(0), "R6 pins in HS", pins, pat(0));

    // R3: arm descent, no mode change yet
    pulse_sr();
    check(mode == 3'd0, "R3 armed no change", mode, 0);
    // R4: second edge while armed ignored (next tick steps once only)
    pulse_sr();
    expect_mode(3'd1); do_tick();
    check(mode == 3'd1, "R4 single step", mode, 1);
    check(pins == pat(1), "R6 pins in LS", pins, pat(1));
    expect_mode(3'd2); do_tick();
    expect_mode(3'd3); do_tick();
    check(mode == 3'd3, "R3 reach sleep", mode, 3);
    do_tick();
    check(mode == 3'd3, "R3 stop at sleep", mode, 3);
    check(pins == pat(3), "R6 pins in sleep", pins, pat(3));

    // R8: bad code ignored, suspend accepted
    req(2'b10);
    check(mode == 3'd3, "R8 bad code ignored", mode, 3);
    expect_mode(3'd4); req(2'b00);
    check(mode == 3'd4, "R8 suspend", mode, 4);
    check(pins == pat(4), "R6 pins in suspend", pins, pat(4));
    req(2'b01);
    check(mode == 3'd4, "R8 off refused outside sleep", mode, 4);

    // R5 from suspend
    expect_mode(3'd0); pulse_sr();
    check(mode == 3'd0, "R5 suspend to HS", mode, 0);
    req(2'b01);
    check(mode == 3'd0, "R8 request in HS ignored", mode, 0);
    do_tick();
    check(mode == 3'd0, "R3 tick without descent", mode, 0);

    // descend again, go to off, return
    pulse_sr();
    expect_mode(3'd1); do_tick();
    expect_mode(3'd2); do_tick();
    expect_mode(3'd3); do_tick();
    expect_mode(3'd5); req(2'b01);
    check(mode == 3'd5, "R8 off from sleep", mode, 5);
    check(pins == pat(5), "R6 pins in off", pins, pat(5));

    // R2: timing of a held-high input from off
    expect_mode(3'd0);
    @(negedge clk) sus_res = 1'b1;
    @(negedge clk);
    check(mode == 3'd5, "R2 one edge no action", mode, 5);
    @(negedge clk);
    check(mode == 3'd5, "R2 two edges no action", mode, 5);
    @(negedge clk);
    check(mode == 3'd0, "R2 action at third edge", mode, 0);
    repeat (4) @(negedge clk);
    do_tick();
    check(mode == 3'd0, "R2 held high not re-armed", mode, 0);
    sus_res = 1'b0;
    repeat (3) @(negedge clk);

    // R7: override released by mode change after a fresh reset
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pins == 4'b1000, "R1 pins after re-reset", pins, 8);
    pulse_sr();
    expect_mode(3'd1); do_tick();
    check(pins == 4'd0, "R7 release on mode change", pins, 0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R9 all changes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule